// File: doc/BRIEF.md
# Write-Leveling Training Sequencer

This block is the controller-side sequencer that steps one DDR3 channel through a write-leveling run for a single target DIMM. A start pulse launches the run with a target DIMM index, a mask of the chip selects that are populated and a flag that selects per-nibble training. The sequencer first puts every populated rank into write-leveling mode with mode-register writes. It then times the DRAM settle period and the ODT settle period, and holds the phy's training enable for a fixed window. Next it strobes the per-lane results into the neighbouring delay registers. Finally it rewrites the mode registers to bring the ranks back to normal operation.

Seed arithmetic, delay recovery and the bit-level encoding of the mode-register values are handled elsewhere. This block only says which rank, which mode register and which of two flags apply: the write-leveling enable for the target DIMM's ranks, and output disable for the other ranks. It also gives the points in time at which the phy loads the ODT pattern, takes its seeds and captures its results.

Top module: `wl_train_seq`

## Requirements
- R1: After reset every output is low, including `busy_o` and `done_o`.
- R2: A high `start_i` while idle samples `target_i`, `cs_mask_i` and `nibble_mode_i` and starts a run. A high `start_i` while busy has no effect on the run.
- R3: Each mode-register phase visits the populated chip selects in ascending order and skips absent ones. Each one gets an MR1 write (`mrs_bank_o` = 1) and then an MR2 write (`mrs_bank_o` = 2). A request holds its rank and bank until `mrs_ack_i`, and the next request follows only after that acknowledge.
- R4: In an entry phase, an MR1 write to a chip select c sets `mrs_wl_o` when c / CS_PER_DIMM equals the target. For every other chip select it sets `mrs_qoff_o` instead. MR2 writes carry both flags low.
- R5: Once the entry writes are done, `odt_load_o` pulses for one cycle with `odt_dimm_o` equal to the target. This pulse never occurs in the exit phase.
- R6: After the ODT load, exactly MOD_WAIT cycles pass with all phy controls low. Then `seed_o` pulses for one cycle.
- R7: `odt_en_o` is high alone for ODT_WAIT cycles. Then `train_en_o` is high together with `odt_en_o` for TRAIN_WAIT cycles.
- R8: In the cycle after `train_en_o` falls, `capture_o` pulses while `odt_en_o` is still high. Then ODT_WAIT cycles follow with all phy controls low.
- R9: With `nibble_mode_i` set, the entry writes, waits, training and capture run twice, with `nibble_o` at 0 and then 1. Without it they run once, with `nibble_o` at 0.
- R10: After the last pass, an exit phase repeats the MR1/MR2 writes for every populated chip select, with `mrs_wl_o` and `mrs_qoff_o` low.
- R11: `done_o` pulses for one cycle at the end of the run, and `busy_o` is low in the next cycle. An empty mask still runs the timed training windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a run (sampled only while idle) |
| target_i | input | DIMM_W | Index of the DIMM to train |
| cs_mask_i | input | NUM_CS | Populated chip selects |
| nibble_mode_i | input | 1 | Train each nibble separately |
| mrs_req_o | output | 1 | Mode-register write request |
| mrs_bank_o | output | 2 | Mode register number (1 or 2) |
| mrs_cs_o | output | CS_W | Chip select of the request |
| mrs_wl_o | output | 1 | MR1 write-leveling enable flag |
| mrs_qoff_o | output | 1 | MR1 output-disable flag |
| mrs_ack_i | input | 1 | Request accepted |
| odt_load_o | output | 1 | Load the target's write-leveling ODT pattern |
| odt_dimm_o | output | DIMM_W | DIMM whose ODT pattern is loaded |
| seed_o | output | 1 | Phy seed programming strobe |
| odt_en_o | output | 1 | Write-leveling ODT enable |
| train_en_o | output | 1 | Phy training enable |
| capture_o | output | 1 | Per-lane result capture strobe |
| nibble_o | output | 1 | Nibble of the current pass |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with four chip selects, two per DIMM, and the full 40/10/200 cycle waits. That size allows a complete sweep: all sixteen chip-select masks, both target DIMMs and both nibble modes. Each run varies the acknowledge latency from zero to two cycles. The sweep covers the empty mask, single ranks at either end, ranks of the non-target DIMM only, and every rank order. Each timed window is counted cycle by cycle against its parameter, and stray start pulses are injected during some runs.

// File: rtl/wl_train_pkg.sv
package wl_train_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_SCAN     = 4'd1,
        ST_MR1      = 4'd2,
        ST_MR2      = 4'd3,
        ST_ODTLD    = 4'd4,
        ST_WMOD     = 4'd5,
        ST_SEED     = 4'd6,
        ST_WODT_ON  = 4'd7,
        ST_TRAIN    = 4'd8,
        ST_CAPT     = 4'd9,
        ST_WODT_OFF = 4'd10,
        ST_DONE     = 4'd11
    } wl_state_e;

    localparam logic [1:0] MR_SEL_1 = 2'd1;
    localparam logic [1:0] MR_SEL_2 = 2'd2;

endpackage

// File: rtl/wl_cs_scan.sv
module wl_cs_scan #(
    parameter int NUM_CS = 4,
    parameter int IDX_W  = 3,
    parameter int CS_W   = 2
) (
    input  logic [NUM_CS-1:0] mask_i,
    input  logic [IDX_W-1:0]  from_i,
    output logic              found_o,
    output logic [CS_W-1:0]   idx_o
);

    // Lowest populated chip select at or above from_i.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (mask_i[i] && (IDX_W'(i) >= from_i)) begin
                found_o = 1'b1;
                idx_o   = CS_W'(i);
            end
        end
    end

endmodule

// File: rtl/wl_wait_timer.sv
module wl_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R6: an unloaded, non-zero count steps down by exactly one
    assert_count_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/wl_train_seq.sv
module wl_train_seq
    import wl_train_pkg::*;
#(
    parameter int NUM_CS      = 4,
    parameter int CS_PER_DIMM = 2,
    parameter int MOD_WAIT    = 40,
    parameter int ODT_WAIT    = 10,
    parameter int TRAIN_WAIT  = 200,
    localparam int NUM_DIMM   = NUM_CS / CS_PER_DIMM,
    localparam int DIMM_W     = (NUM_DIMM > 1) ? $clog2(NUM_DIMM) : 1,
    localparam int CS_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [DIMM_W-1:0] target_i,
    input  logic [NUM_CS-1:0] cs_mask_i,
    input  logic              nibble_mode_i,
    output logic              mrs_req_o,
    output logic [1:0]        mrs_bank_o,
    output logic [CS_W-1:0]   mrs_cs_o,
    output logic              mrs_wl_o,
    output logic              mrs_qoff_o,
    input  logic              mrs_ack_i,
    output logic              odt_load_o,
    output logic [DIMM_W-1:0] odt_dimm_o,
    output logic              seed_o,
    output logic              odt_en_o,
    output logic              train_en_o,
    output logic              capture_o,
    output logic              nibble_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int IDX_W  = CS_W + 1;
    localparam int MAX_AB = (MOD_WAIT > ODT_WAIT) ? MOD_WAIT : ODT_WAIT;
    localparam int MAX_W  = (TRAIN_WAIT > MAX_AB) ? TRAIN_WAIT : MAX_AB;
    localparam int TMR_W  = $clog2(MAX_W) + 1;

    typedef struct packed {
        wl_state_e         state;
        logic [IDX_W-1:0]  cs_next;
        logic [CS_W-1:0]   cs_cur;
        logic [DIMM_W-1:0] target;
        logic [NUM_CS-1:0] mask;
        logic              nib_mode;
        logic              nibble;
        logic              wl_phase;
    } seq_t;

    seq_t q, d;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             scan_found;
    logic [CS_W-1:0]  scan_idx;
    logic             cur_is_target;

    wl_cs_scan #(
        .NUM_CS (NUM_CS),
        .IDX_W  (IDX_W),
        .CS_W   (CS_W)
    ) u_scan (
        .mask_i  (q.mask),
        .from_i  (q.cs_next),
        .found_o (scan_found),
        .idx_o   (scan_idx)
    );

    wl_wait_timer #(
        .W (TMR_W)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state    = ST_SCAN;
                    d.target   = target_i;
                    d.mask     = cs_mask_i;
                    d.nib_mode = nibble_mode_i;
                    d.nibble   = 1'b0;
                    d.wl_phase = 1'b1;
                    d.cs_next  = '0;
                end
            end
            ST_SCAN: begin
                if (scan_found) begin
                    d.cs_cur = scan_idx;
                    d.state  = ST_MR1;
                end else if (q.wl_phase) begin
                    d.state = ST_ODTLD;
                end else begin
                    d.state = ST_DONE;
                end
            end
            ST_MR1: begin
                if (mrs_ack_i) begin
                    d.state = ST_MR2;
                end
            end
            ST_MR2: begin
                if (mrs_ack_i) begin
                    d.cs_next = IDX_W'(q.cs_cur) + 1'b1;
                    d.state   = ST_SCAN;
                end
            end
            ST_ODTLD: begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(MOD_WAIT - 1);
                d.state  = ST_WMOD;
            end
            ST_WMOD: begin
                if (tmr_zero) begin
                    d.state = ST_SEED;
                end
            end
            ST_SEED: begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(ODT_WAIT - 1);
                d.state  = ST_WODT_ON;
            end
            ST_WODT_ON: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(TRAIN_WAIT - 1);
                    d.state  = ST_TRAIN;
                end
            end
            ST_TRAIN: begin
                if (tmr_zero) begin
                    d.state = ST_CAPT;
                end
            end
            ST_CAPT: begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(ODT_WAIT - 1);
                d.state  = ST_WODT_OFF;
            end
            ST_WODT_OFF: begin
                if (tmr_zero) begin
                    d.cs_next = '0;
                    d.state   = ST_SCAN;
                    if (q.nib_mode && !q.nibble) begin
                        d.nibble = 1'b1;
                    end else begin
                        d.wl_phase = 1'b0;
                    end
                end
            end
            ST_DONE: begin
                d.state = ST_IDLE;
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cur_is_target = (DIMM_W'(int'(q.cs_cur) / CS_PER_DIMM) == q.target);

    assign mrs_req_o  = (q.state == ST_MR1) || (q.state == ST_MR2);
    assign mrs_bank_o = (q.state == ST_MR2) ? MR_SEL_2 : ((q.state == ST_MR1) ? MR_SEL_1 : 2'd0);
    assign mrs_cs_o   = q.cs_cur;
    assign mrs_wl_o   = (q.state == ST_MR1) && q.wl_phase && cur_is_target;
    assign mrs_qoff_o = (q.state == ST_MR1) && q.wl_phase && !cur_is_target;
    assign odt_load_o = (q.state == ST_ODTLD);
    assign odt_dimm_o = q.target;
    assign seed_o     = (q.state == ST_SEED);
    assign odt_en_o   = (q.state == ST_WODT_ON) || (q.state == ST_TRAIN) || (q.state == ST_CAPT);
    assign train_en_o = (q.state == ST_TRAIN);
    assign capture_o  = (q.state == ST_CAPT);
    assign nibble_o   = q.nibble;
    assign busy_o     = (q.state != ST_IDLE);
    assign done_o     = (q.state == ST_DONE);

    // R3: a pending request keeps its rank and register until acknowledged
    assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mrs_req_o && !mrs_ack_i) |=> (mrs_req_o && $stable(mrs_cs_o) && $stable(mrs_bank_o)));

    // R3: no mode-register traffic while the phy is driven for training
    assert_quiet_bus_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (odt_en_o || odt_load_o || seed_o) |-> !mrs_req_o);

    // R4: the two MR1 flags never coincide
    assert_flags_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mrs_wl_o && mrs_qoff_o));

    // R7: training only under write-leveling ODT
    assert_train_in_odt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        train_en_o |-> odt_en_o);

    // R7: ODT was already settling when training starts
    assert_train_after_odt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(train_en_o) |-> $past(odt_en_o));

    // R8: capture follows the fall of training with ODT still on
    assert_capture_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        capture_o |-> ($past(train_en_o) && !train_en_o && odt_en_o));

    // R11: done lasts one cycle and leaves the block idle
    assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (!done_o && !busy_o));

endmodule

// File: tb/wl_train_seq_bench.sv
module wl_train_seq_bench;

    localparam int NUM_CS      = 4;
    localparam int CS_PER_DIMM = 2;
    localparam int MOD_WAIT    = 40;
    localparam int ODT_WAIT    = 10;
    localparam int TRAIN_WAIT  = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [0:0] target = '0;
    logic [3:0] mask = '0;
    logic       nib_mode = 1'b0;
    logic       ack = 1'b0;
    logic       req, wl, qoff, odt_load, seed, odt_en, train_en, capture, nibble, busy, done;
    logic [1:0] bank;
    logic [1:0] cs;
    logic [0:0] odt_dimm;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wl_train_seq #(
        .NUM_CS      (NUM_CS),
        .CS_PER_DIMM (CS_PER_DIMM),
        .MOD_WAIT    (MOD_WAIT),
        .ODT_WAIT    (ODT_WAIT),
        .TRAIN_WAIT  (TRAIN_WAIT)
    ) u_wl_train_seq (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .start_i       (start),
        .target_i      (target),
        .cs_mask_i     (mask),
        .nibble_mode_i (nib_mode),
        .mrs_req_o     (req),
        .mrs_bank_o    (bank),
        .mrs_cs_o      (cs),
        .mrs_wl_o      (wl),
        .mrs_qoff_o    (qoff),
        .mrs_ack_i     (ack),
        .odt_load_o    (odt_load),
        .odt_dimm_o    (odt_dimm),
        .seed_o        (seed),
        .odt_en_o      (odt_en),
        .train_en_o    (train_en),
        .capture_o     (capture),
        .nibble_o      (nibble),
        .busy_o        (busy),
        .done_o        (done)
    );

    task automatic check(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Phy controls packed as {odt_en, train_en, capture, seed, odt_load, req}
    task automatic expect_win(int n, logic [5:0] exp, bit nib, string rq, string what);
        bit bad = 1'b0;
        logic [5:0] got = '0;
        logic [5:0] first_bad = '0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            got = {odt_en, train_en, capture, seed, odt_load, req};
            if (!bad && ((got !== exp) || (nibble !== nib))) begin
                bad = 1'b1;
                first_bad = got;
            end
        end
        check(!bad, rq, what, int'(first_bad), int'(exp));
    endtask

    task automatic mrs_phase(logic [3:0] m, logic [0:0] t, bit entry, int ackdly);
        for (int c = 0; c < NUM_CS; c++) begin
            if (m[c]) begin
                for (int b = 1; b <= 2; b++) begin
                    bit seen = 1'b0;
                    bit hold_ok = 1'b1;
                    bit exp_wl;
                    bit exp_qoff;
                    for (int k = 0; k < 8; k++) begin
                        if (req) begin
                            seen = 1'b1;
                            break;
                        end
                        @(negedge clk);
                    end
                    check(seen, "R3", "request issued", int'(seen), 1);
                    check(cs == 2'(c), "R3", "ascending chip select", int'(cs), c);
                    check(bank == 2'(b), "R3", "MR1 then MR2", int'(bank), b);
                    exp_wl   = entry && (b == 1) && ((c / CS_PER_DIMM) == int'(t));
                    exp_qoff = entry && (b == 1) && ((c / CS_PER_DIMM) != int'(t));
                    check(wl == exp_wl, entry ? "R4" : "R10", "write-level flag", int'(wl), int'(exp_wl));
                    check(qoff == exp_qoff, entry ? "R4" : "R10", "output-off flag", int'(qoff), int'(exp_qoff));
                    for (int k = 0; k < ackdly; k++) begin
                        @(negedge clk);
                        if (!req || (cs != 2'(c)) || (bank != 2'(b))) hold_ok = 1'b0;
                    end
                    if (ackdly > 0) check(hold_ok, "R3", "request held until ack", int'(hold_ok), 1);
                    ack = 1'b1;
                    @(negedge clk);
                    ack = 1'b0;
                end
            end
        end
    endtask

    task automatic run_case(logic [3:0] m, logic [0:0] t, bit nm, int ackdly, bit poke);
        int npass = nm ? 2 : 1;
        bit got_done = 1'b0;
        bit no_load = 1'b1;
        check(!busy && !done, "R11", "idle before run", int'(busy), 0);
        target   = t;
        mask     = m;
        nib_mode = nm;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        // Inputs changed after launch must not matter (R2)
        target   = ~t;
        mask     = ~m;
        nib_mode = ~nm;
        check(busy, "R2", "busy after start", int'(busy), 1);
        for (int p = 0; p < npass; p++) begin
            bit seen_load = 1'b0;
            bit quiet = 1'b1;
            mrs_phase(m, t, 1'b1, ackdly);
            for (int k = 0; k < 4; k++) begin
                if (odt_load) begin
                    seen_load = 1'b1;
                    break;
                end
                if (req) quiet = 1'b0;
                @(negedge clk);
            end
            check(seen_load && quiet, "R5", "ODT load after entry writes", int'(seen_load), 1);
            check(odt_dimm == t, "R5", "ODT pattern DIMM", int'(odt_dimm), int'(t));
            check(nibble == 1'(p), "R9", "nibble of pass", int'(nibble), p);
            if (poke) begin
                start  = 1'b1;
                expect_win(1, 6'b000000, 1'(p), "R2", "start ignored while busy");
                start  = 1'b0;
                expect_win(MOD_WAIT - 1, 6'b000000, 1'(p), "R6", "mode settle window");
            end else begin
                expect_win(MOD_WAIT, 6'b000000, 1'(p), "R6", "mode settle window");
            end
            expect_win(1, 6'b000100, 1'(p), "R6", "seed strobe");
            expect_win(ODT_WAIT, 6'b100000, 1'(p), "R7", "ODT settle window");
            expect_win(TRAIN_WAIT, 6'b110000, 1'(p), "R7", "training window");
            expect_win(1, 6'b101000, 1'(p), "R8", "capture strobe");
            expect_win(ODT_WAIT, 6'b000000, 1'(p), "R8", "ODT release window");
        end
        mrs_phase(m, t, 1'b0, ackdly);
        for (int k = 0; k < 4; k++) begin
            if (done) begin
                got_done = 1'b1;
                break;
            end
            if (odt_load || odt_en) no_load = 1'b0;
            @(negedge clk);
        end
        check(no_load, "R5", "no ODT load on exit", int'(no_load), 1);
        check(got_done, "R11", "done pulse", int'(got_done), 1);
        check(nibble == nm, "R9", "passes completed", int'(nibble), int'(nm));
        @(negedge clk);
        check(!done && !busy, "R11", "idle after done", int'({done, busy}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs after reset
        check({req, wl, qoff, odt_load, seed, odt_en, train_en, capture, busy, done} == '0,
              "R1", "outputs in reset", int'({req, odt_en, train_en, busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({req, wl, qoff, odt_load, seed, odt_en, train_en, capture, busy, done} == '0,
              "R1", "outputs after reset", int'({req, odt_en, train_en, busy, done}), 0);
        for (int m = 0; m < 16; m++) begin
            for (int t = 0; t < 2; t++) begin
                for (int n = 0; n < 2; n++) begin
                    run_case(4'(m), 1'(t), n[0], (m + t + n) % 3, (m % 3) == 1);
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule